// File: doc/BRIEF.md
# 16-bit Register-Pair Adder/Subtractor

This block is the combinational arithmetic path for 16-bit register-pair operations in an 8-bit processor datapath. It adds a 16-bit operand into a 16-bit accumulator pair, or subtracts it from that pair. There are three operations: a plain add, an add that includes the carry flag, and a subtract that includes the carry flag as a borrow.

The block returns the 16-bit result together with a new flag byte. The flag byte uses the same bit layout as the byte-wide ALU. The plain add keeps part of the incoming flag byte unchanged. The two carry variants compute every flag again from the full 16-bit result. The caller selects the operation with a two-bit code and supplies the current flag byte. It then writes the result and the new flags back into its registers.

Flag byte layout (bit: meaning): 7 sign, 6 zero, 5 copy of result bit 13, 4 half-carry, 3 copy of result bit 11, 2 overflow, 1 subtract, 0 carry.

Top module: `rp_pair_alu`

## Requirements
- R1: With op code 2'b00 (plain add), the result is acc + opnd modulo 2^16, and incoming flag bit 0 has no effect on the result.
- R2: With op code 2'b01 (add with carry), the result is acc + opnd + flags_in[0] modulo 2^16.
- R3: With op code 2'b10 (subtract with borrow), the result is acc - opnd - flags_in[0] modulo 2^16.
- R4: Flag bit 0 is the carry out of bit 15 for the add operations. For the subtract it is the borrow out of bit 15.
- R5: Flag bit 4 is the carry (for add) or the borrow (for subtract) that crosses from bit 11 into bit 12.
- R6: For plain add, flag bits 7, 6 and 2 equal the incoming flag bits 7, 6 and 2.
- R7: For add-with-carry and subtract-with-borrow, flag bit 6 is set only when all 16 result bits are zero, and flag bit 7 equals result bit 15.
- R8: For add-with-carry and subtract-with-borrow, flag bit 2 reports two's-complement overflow of the 16-bit operation. For the subtract this means the operands differ in bit 15 and the result's bit 15 differs from acc bit 15.
- R9: Flag bit 1 is 1 for subtract-with-borrow and 0 for both add operations.
- R10: For every operation, flag bits 5 and 3 equal result bits 13 and 11.
- R11: Op code 2'b11 behaves exactly like plain add.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 2 | Operation: 00 add, 01 add with carry, 10 subtract with borrow, 11 add |
| acc_in | input | 16 | Accumulator pair (first operand) |
| opnd_in | input | 16 | Second operand |
| flags_in | input | 8 | Current flag byte |
| result_out | output | 16 | 16-bit result |
| flags_out | output | 8 | Updated flag byte |

## Verification
The block has no state, so an error in the shared sum core appears on both outputs within the same evaluation. A single wrong carry chain or a wrong inversion on the subtract path changes the result and flag bit 0 together. A wrong tap for the half-carry boundary only shows when an operand pair carries across bit 11, so the bench drives values such as 0x0FFF against 1. It also drives the sign boundary 0x7FFF/0x8000 for overflow, and compares every flag bit against a model written from the requirements.

// File: rtl/rp_alu_pkg.sv
// Shared definitions for the register-pair adder/subtractor.
// Assumes the flag byte layout shared with the byte-wide ALU.
package rp_alu_pkg;

    typedef enum logic [1:0] {
        RP_ADD = 2'b00,
        RP_ADC = 2'b01,
        RP_SBC = 2'b10,
        RP_RSV = 2'b11
    } rp_op_e;

    localparam int FLAG_W   = 8;
    localparam int FB_CARRY = 0;
    localparam int FB_SUB   = 1;
    localparam int FB_OVF   = 2;
    localparam int FB_X3    = 3;
    localparam int FB_HALF  = 4;
    localparam int FB_X5    = 5;
    localparam int FB_ZERO  = 6;
    localparam int FB_SIGN  = 7;

endpackage

// File: rtl/rp_sum_core.sv
// Carry-chain core: computes a + b + cin, or a - b - cin when sub is set.
// It reports the carry/borrow out of the top bit, the carry/borrow into
// bit HC_POS, and the signed overflow.
// Assumes WIDTH > HC_POS > 0.
module rp_sum_core #(
    parameter int WIDTH  = 16,
    parameter int HC_POS = 12
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    input  logic             sub,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             hc,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic             c_eff;
    logic [WIDTH:0]   wide;
    logic [WIDTH-1:0] carry_in_vec;

    // Invert operand and carry for subtract so one adder serves both.
    always_comb begin
        b_eff = sub ? ~b : b;
        c_eff = sub ? ~cin : cin;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, c_eff};
    end

    // Derive outputs; on subtract an absent carry means a borrow.
    always_comb begin
        sum          = wide[MSB:0];
        cout         = wide[WIDTH] ^ sub;
        carry_in_vec = a ^ b_eff ^ wide[MSB:0];
        hc           = carry_in_vec[HC_POS] ^ sub;
        ovf          = (a[MSB] == b_eff[MSB]) && (wide[MSB] != a[MSB]);
    end

endmodule

// File: rtl/rp_flag_pack.sv
// Assembles the updated flag byte from the sum core outputs.
// Plain add keeps sign, zero and overflow from the incoming byte; the
// carry variants compute them again from the full result.
// Assumes WIDTH >= 14 so that the bit-13 and bit-11 copies exist.
module rp_flag_pack
    import rp_alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  rp_op_e            op,
    input  logic [FLAG_W-1:0] flags_in,
    input  logic [WIDTH-1:0]  sum,
    input  logic              cout,
    input  logic              hc,
    input  logic              ovf,
    output logic [FLAG_W-1:0] flags_out
);
    localparam int MSB   = WIDTH - 1;
    localparam int X5_SRC = WIDTH - 3;
    localparam int X3_SRC = WIDTH - 5;

    logic keep_szv;
    logic is_sub;

    // Classify the operation.
    always_comb begin
        keep_szv = (op == RP_ADD) || (op == RP_RSV);
        is_sub   = (op == RP_SBC);
    end

    // Build each flag bit.
    always_comb begin
        flags_out           = '0;
        flags_out[FB_CARRY] = cout;
        flags_out[FB_SUB]   = is_sub;
        flags_out[FB_HALF]  = hc;
        flags_out[FB_X5]    = sum[X5_SRC];
        flags_out[FB_X3]    = sum[X3_SRC];
        if (keep_szv) begin
            flags_out[FB_SIGN] = flags_in[FB_SIGN];
            flags_out[FB_ZERO] = flags_in[FB_ZERO];
            flags_out[FB_OVF]  = flags_in[FB_OVF];
        end else begin
            flags_out[FB_SIGN] = sum[MSB];
            flags_out[FB_ZERO] = (sum == '0);
            flags_out[FB_OVF]  = ovf;
        end
    end

endmodule

// File: rtl/rp_pair_alu.sv
// Top of the 16-bit register-pair adder/subtractor. Purely combinational.
// It decodes the operation, feeds the sum core and packs the flags.
// Assumes the caller registers the outputs.
module rp_pair_alu
    import rp_alu_pkg::*;
#(
    parameter int WIDTH  = 16,
    parameter int HC_POS = 12
) (
    input  logic [1:0]        op_sel,
    input  logic [WIDTH-1:0]  acc_in,
    input  logic [WIDTH-1:0]  opnd_in,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [WIDTH-1:0]  result_out,
    output logic [FLAG_W-1:0] flags_out
);
    rp_op_e op;
    logic   use_cin;
    logic   do_sub;
    logic   cin;
    logic   cout;
    logic   hc;
    logic   ovf;

    // Decode the operation code into core controls.
    always_comb begin
        op      = rp_op_e'(op_sel);
        use_cin = (op == RP_ADC) || (op == RP_SBC);
        do_sub  = (op == RP_SBC);
        cin     = use_cin & flags_in[FB_CARRY];
    end

    rp_sum_core #(
        .WIDTH (WIDTH),
        .HC_POS(HC_POS)
    ) u_core (
        .a   (acc_in),
        .b   (opnd_in),
        .cin (cin),
        .sub (do_sub),
        .sum (result_out),
        .cout(cout),
        .hc  (hc),
        .ovf (ovf)
    );

    rp_flag_pack #(
        .WIDTH(WIDTH)
    ) u_flags (
        .op       (op),
        .flags_in (flags_in),
        .sum      (result_out),
        .cout     (cout),
        .hc       (hc),
        .ovf      (ovf),
        .flags_out(flags_out)
    );

endmodule

// File: rtl/rp_pair_alu_chk.sv
// Checker for rp_pair_alu: immediate assertions on the ports, evaluated
// whenever every input is known.
module rp_pair_alu_chk (
    input logic [1:0]  op_sel,
    input logic [15:0] acc_in,
    input logic [15:0] opnd_in,
    input logic [7:0]  flags_in,
    input logic [15:0] result_out,
    input logic [7:0]  flags_out
);
    logic known;
    logic plain;
    logic [15:0] add_ref;

    // Gate checks on fully known inputs and classify the operation.
    always_comb begin
        known   = !$isunknown({op_sel, acc_in, opnd_in, flags_in});
        plain   = (op_sel == 2'b00) || (op_sel == 2'b11);
        add_ref = acc_in + opnd_in;
    end

    // Port-level checks.
    always_comb begin
        if (known) begin
            // R1
            plain_sum_chk: assert (!plain || result_out == add_ref);
            // R6
            keep_flags_chk: assert (!plain ||
                (flags_out[7] == flags_in[7] && flags_out[6] == flags_in[6] &&
                 flags_out[2] == flags_in[2]));
            // R7
            full_zero_chk: assert (plain || flags_out[6] == (result_out == 16'h0000));
            // R7
            sign_bit_chk: assert (plain || flags_out[7] == result_out[15]);
            // R9
            sub_flag_chk: assert (flags_out[1] == (op_sel == 2'b10));
            // R10
            copy_bits_chk: assert (flags_out[5] == result_out[13] &&
                                   flags_out[3] == result_out[11]);
        end
    end

endmodule

bind rp_pair_alu rp_pair_alu_chk u_rp_pair_alu_chk (
    .op_sel    (op_sel),
    .acc_in    (acc_in),
    .opnd_in   (opnd_in),
    .flags_in  (flags_in),
    .result_out(result_out),
    .flags_out (flags_out)
);

// File: tb/test_rp_pair_alu.sv
// Directed bench for rp_pair_alu: one task per scenario, each checking
// its own results against a model written from the requirements.
module test_rp_pair_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_sel = 2'b00;
    logic [15:0] acc_in = '0;
    logic [15:0] opnd_in = '0;
    logic [7:0]  flags_in = '0;
    logic [15:0] result_out;
    logic [7:0]  flags_out;

    int n_checks = 0;
    int n_errors = 0;
    logic [31:0] lfsr = 32'h1234_5678;

    always #5ns clk = ~clk;

    rp_pair_alu i_rp_pair_alu (
        .op_sel    (op_sel),
        .acc_in    (acc_in),
        .opnd_in   (opnd_in),
        .flags_in  (flags_in),
        .result_out(result_out),
        .flags_out (flags_out)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Model built from R1..R11.
    task automatic model(input logic [1:0] op, input logic [15:0] a, input logic [15:0] b,
                         input logic [7:0] f, output logic [15:0] r, output logic [7:0] fo);
        int c, raw, hraw, sa, sb, sr;
        bit cf, hf, vf;
        c  = (op == 2'b01 || op == 2'b10) ? int'(f[0]) : 0;
        sa = int'($signed(a));
        sb = int'($signed(b));
        if (op == 2'b10) begin
            raw  = int'(a) - int'(b) - c;
            cf   = raw < 0;
            hraw = int'(a & 16'h0FFF) - int'(b & 16'h0FFF) - c;
            hf   = hraw < 0;
            sr   = sa - sb - c;
        end else begin
            raw  = int'(a) + int'(b) + c;
            cf   = raw > 32'hFFFF;
            hraw = int'(a & 16'h0FFF) + int'(b & 16'h0FFF) + c;
            hf   = hraw > 32'h0FFF;
            sr   = sa + sb + c;
        end
        vf = (sr > 32767) || (sr < -32768);
        r  = raw[15:0];
        if (op == 2'b00 || op == 2'b11)
            fo = {f[7], f[6], r[13], hf, r[11], f[2], 1'b0, cf};
        else
            fo = {r[15], (r == 16'h0), r[13], hf, r[11], vf, (op == 2'b10), cf};
    endtask

    task automatic drive(input logic [1:0] op, input logic [15:0] a, input logic [15:0] b,
                         input logic [7:0] f);
        @(posedge clk);
        #1ns;
        op_sel = op; acc_in = a; opnd_in = b; flags_in = f;
        @(negedge clk);
    endtask

    // Apply one vector and compare every output field with its requirement.
    task automatic run_vec(input logic [1:0] op, input logic [15:0] a, input logic [15:0] b,
                           input logic [7:0] f);
        logic [15:0] er;
        logic [7:0]  ef;
        bit plain;
        model(op, a, b, f, er, ef);
        drive(op, a, b, f);
        plain = (op == 2'b00 || op == 2'b11);
        case (op)
            2'b00: chk("R1 result", result_out, er);
            2'b01: chk("R2 result", result_out, er);
            2'b10: chk("R3 result", result_out, er);
            default: chk("R11 result", result_out, er);
        endcase
        chk("R4 carry", 16'(flags_out[0]), 16'(ef[0]));
        chk("R9 subtract", 16'(flags_out[1]), 16'(ef[1]));
        chk(plain ? "R6 overflow kept" : "R8 overflow", 16'(flags_out[2]), 16'(ef[2]));
        chk("R10 bit3", 16'(flags_out[3]), 16'(ef[3]));
        chk("R5 half", 16'(flags_out[4]), 16'(ef[4]));
        chk("R10 bit5", 16'(flags_out[5]), 16'(ef[5]));
        chk(plain ? "R6 zero kept" : "R7 zero", 16'(flags_out[6]), 16'(ef[6]));
        chk(plain ? "R6 sign kept" : "R7 sign", 16'(flags_out[7]), 16'(ef[7]));
    endtask

    function automatic logic [15:0] next_rand();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lfsr[15:0];
    endfunction

    // Quiet inputs during reset give a zero sum and clear flags (R1, R4).
    task automatic t_reset_state();
        @(negedge clk);
        chk("R1 reset result", result_out, 16'h0000);
        chk("R4 reset flags", 16'(flags_out), 16'h0000);
    endtask

    // Hand-worked vectors at the boundaries named in the requirements.
    task automatic t_hand_values();
        drive(2'b00, 16'h0FFF, 16'h0001, 8'h00);
        chk("R5 half at bit 11 (add)", result_out, 16'h1000);
        chk("R5 flags 0FFF+1", 16'(flags_out), 16'h0010);
        drive(2'b10, 16'h8000, 16'h0001, 8'h00);
        chk("R3 8000-1", result_out, 16'h7FFF);
        chk("R8 flags 8000-1", 16'(flags_out), 16'h003E);
        drive(2'b01, 16'hFFFF, 16'h0000, 8'h01);
        chk("R2 FFFF+0+1", result_out, 16'h0000);
        chk("R7 flags FFFF+0+1", 16'(flags_out), 16'h0051);
        drive(2'b00, 16'h7FFF, 16'h0001, 8'hC5);
        chk("R1 carry-in ignored", result_out, 16'h8000);
        chk("R6 flags kept", 16'(flags_out), 16'h00D4);
    endtask

    // Every pair of corner operands, every op, both carry-in values.
    task automatic t_corners();
        logic [15:0] cv [5] = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h0FFF};
        for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
                for (int op = 0; op < 4; op++)
                    for (int c = 0; c < 2; c++)
                        run_vec(2'(op), cv[i], cv[j], (c != 0) ? 8'hC5 : 8'h3A);
    endtask

    // Pseudo-random operands and flag bytes for each operation.
    task automatic t_random();
        for (int k = 0; k < 300; k++) begin
            logic [15:0] a, b, f;
            a = next_rand();
            b = next_rand();
            f = next_rand();
            run_vec(2'(k % 4), a, b, f[7:0]);
        end
    endtask

    // Code 11 matches plain add on the same inputs (R11).
    task automatic t_reserved_code();
        logic [15:0] r_add;
        logic [7:0]  f_add;
        drive(2'b00, 16'h1234, 16'hEDCC, 8'hA7);
        r_add = result_out;
        f_add = flags_out;
        drive(2'b11, 16'h1234, 16'hEDCC, 8'hA7);
        chk("R11 result matches add", result_out, r_add);
        chk("R11 flags match add", 16'(flags_out), 16'(f_add));
    endtask

    initial begin
        #2ms;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset_state();
        @(posedge clk);
        rst_n = 1'b1;
        t_hand_values();
        t_corners();
        t_random();
        t_reserved_code();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule